// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces CAS-before-RAS refresh for a DRAM controller. A 14-bit up counter runs freely on the core clock and is compared for equality against a programmable interval. When the two agree, the block raises a refresh request toward the memory arbiter, and the counter restarts. The result is one request every N clocks, where N is the programmed interval. For example, an interval of 780 at a 50 MHz clock gives a refresh every 15.6 µs.

Software reaches the block through a small synchronous register port. Address 0 holds the interval. Address 1 holds a sticky flag that records a refresh that was dropped. The request leaves the block as a valid/ready stream with no payload. Valid rises one clock after a counter match and stays high until ready is seen at a rising edge. The arbiter may hold ready low for as long as it likes; this is back-pressure. If it holds ready low long enough for the next match to arrive, the block does not queue a second request. The two requests merge into the one that is still pending, and the lost flag is set. This case arises when an extended external bus cycle keeps the arbiter busy.

Because the period comes from an equality match rather than a reloading down counter, a change to the interval does not restart the count. If the new interval is below the current count, the next request comes only after the counter wraps through 0x3FFF.

Top module: `refresh_interval_timer`

## Requirements
- R1: After reset, the interval reads 0x3FFF, the lost flag and the request are low, and the counter is 0.
- R2: A write to address 0 stores wdata[13:0] as the interval. Reading address 0 returns the interval in bits 13:0 with bits 15:14 as 0, whatever was written there. Reading address 1 returns the lost flag in bit 0 with all other bits 0. Any other address reads 0.
- R3: With a nonzero interval N and ready held high, requests are exactly N clocks apart. After a match the counter continues from 1.
- R4: Once raised, the request stays high until ready is high at a rising edge. In the cycle after that handshake it is low, unless a new match occurred in the same cycle.
- R5: A write to the interval is used for comparison from the next clock and does not disturb the counter. If the new value is below the current count, no request occurs until the counter wraps from 0x3FFF to 0 and climbs to the new value.
- R6: A match while a request is pending and ready is low sets the lost flag. The outstanding request remains a single request that is still high.
- R7: The lost flag is sticky. Writing 1 to bit 0 of address 1 clears it, and writing 0 there leaves it unchanged. A new loss in the same cycle as a clear wins.
- R8: An interval of 0 produces no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address (0 interval, 1 status) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| rfsh_valid | output | 1 | Refresh request |
| rfsh_ready | input | 1 | Arbiter accepts the request |
| rfsh_lost | output | 1 | Sticky flag: a refresh was dropped |

## Verification
The hardest case to reach from the ports is the late-interval write. The interval must be lowered below a counter value that the bench cannot read directly, and the block must then stay quiet for nearly the full 16384-clock wrap. To set this up, the bench waits for a request at an interval of 200, which places the counter at a known value. It lets about a hundred clocks pass and then writes 50. It confirms silence for a long window and checks that the next request arrives only after the wrap, while a behavioural model is compared on every clock. Lost refreshes are produced by holding ready low across a following match, both with and without a clear in flight.

// File: rtl/rit_pkg.sv
package rit_pkg;
  localparam int RIT_DATA_W = 16;
  localparam int RIT_CNT_W  = 14;
  localparam int RIT_ADDR_W = 2;
  localparam logic [RIT_ADDR_W-1:0] RIT_A_IVAL = 2'd0;
  localparam logic [RIT_ADDR_W-1:0] RIT_A_STAT = 2'd1;
endpackage

// File: rtl/rit_regs.sv
module rit_regs
  import rit_pkg::*;
#(
  parameter int DATA_W = RIT_DATA_W,
  parameter int CNT_W  = RIT_CNT_W,
  parameter int ADDR_W = RIT_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lost,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  interval,
  output logic              lost_clr
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [CNT_W-1:0] ival_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ival_q <= '1;
    else if (we && addr == ADDR_W'(RIT_A_IVAL)) ival_q <= wdata[CNT_W-1:0];
  end

  assign interval = ival_q;
  assign lost_clr = we && (addr == ADDR_W'(RIT_A_STAT)) && wdata[0];

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(RIT_A_IVAL))      rdata = {{PAD_W{1'b0}}, ival_q};
    else if (addr == ADDR_W'(RIT_A_STAT)) rdata = {{(DATA_W-1){1'b0}}, lost};
  end
endmodule

// File: rtl/rit_counter.sv
module rit_counter
  import rit_pkg::*;
#(
  parameter int CNT_W = RIT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q;

  assign match = (interval != '0) && (cnt_q == interval);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (match) cnt_q <= CNT_W'(1);
    else            cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/rit_req.sv
module rit_req (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic ready,
  input  logic lost_clr,
  output logic valid,
  output logic lost
);
  logic valid_q, lost_q, drop;

  assign drop = match && valid_q && !ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      valid_q <= match || (valid_q && !ready);
      lost_q  <= drop || (lost_q && !lost_clr);
    end
  end

  assign valid = valid_q;
  assign lost  = lost_q;
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
  import rit_pkg::*;
#(
  parameter int DATA_W = RIT_DATA_W,
  parameter int CNT_W  = RIT_CNT_W,
  parameter int ADDR_W = RIT_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rfsh_valid,
  input  logic              rfsh_ready,
  output logic              rfsh_lost
);
  logic [CNT_W-1:0] interval;
  logic [CNT_W-1:0] count;
  logic             match;
  logic             lost_clr;

  rit_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .lost(rfsh_lost), .rdata(reg_rdata), .interval(interval), .lost_clr(lost_clr)
  );

  rit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .interval(interval), .count(count), .match(match)
  );

  rit_req u_req (
    .clk(clk), .rst_n(rst_n), .match(match), .ready(rfsh_ready),
    .lost_clr(lost_clr), .valid(rfsh_valid), .lost(rfsh_lost)
  );
endmodule

// File: rtl/rit_checker.sv
module rit_checker #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rfsh_valid,
  input logic             rfsh_ready,
  input logic             rfsh_lost,
  input logic             match,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] interval
);
  a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_valid && !rfsh_ready |=> rfsh_valid);

  a_r4_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_valid && rfsh_ready && !match |=> !rfsh_valid);

  a_r6_lost_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_lost) |-> $past(rfsh_valid && !rfsh_ready && match));

  a_r3_restart_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> count == CNT_W'(1));

  a_r5_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '1) && !match |=> count == '0);

  a_r8_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    interval == '0 |-> !match);
endmodule

bind refresh_interval_timer rit_checker #(.CNT_W(CNT_W)) u_rit_chk (
  .clk(clk), .rst_n(rst_n), .rfsh_valid(rfsh_valid), .rfsh_ready(rfsh_ready),
  .rfsh_lost(rfsh_lost), .match(match), .count(count), .interval(interval)
);

// File: tb/test_refresh_interval_timer.sv
module test_refresh_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        rfsh_valid;
  logic        rfsh_ready = 1'b1;
  logic        rfsh_lost;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference
  int m_cnt, m_ival;
  bit m_pend, m_lost;

  always #5 clk = ~clk;

  refresh_interval_timer i_refresh_interval_timer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rfsh_valid(rfsh_valid),
    .rfsh_ready(rfsh_ready), .rfsh_lost(rfsh_lost)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ival = 16'h3FFF; m_pend = 0; m_lost = 0;
    end else begin
      bit hit, drop;
      hit  = (m_ival != 0) && (m_cnt == m_ival);
      drop = hit && m_pend && !rfsh_ready;
      m_lost = drop || (m_lost && !(reg_we && reg_addr == 2'd1 && reg_wdata[0]));
      m_pend = hit || (m_pend && !rfsh_ready);
      m_cnt  = hit ? 1 : (m_cnt + 1) % 16384;
      if (reg_we && reg_addr == 2'd0) m_ival = reg_wdata & 16'h3FFF;
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      int exp_rd;
      exp_rd = (reg_addr == 2'd0) ? m_ival : (reg_addr == 2'd1) ? int'(m_lost) : 0;
      chk("R4 request vs model", rfsh_valid, m_pend);
      chk("R6 lost vs model", rfsh_lost, m_lost);
      chk("R2 read data vs model", reg_rdata, exp_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!rfsh_valid && n < 20000);
  endtask

  initial begin
    int n, seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 interval after reset", reg_rdata, 16'h3FFF);
    chk("R1 request after reset", rfsh_valid, 0);
    reg_addr = 2'd1; #1;
    chk("R1 lost after reset", reg_rdata, 0);
    reg_addr = 2'd0;
    // R2 reserved bits ignored
    wr(2'd0, 16'hC005);
    #1 chk("R2 reserved bits read zero", reg_rdata, 16'h0005);
    reg_addr = 2'd3; #1;
    chk("R2 unused address reads zero", reg_rdata, 0);
    reg_addr = 2'd0;
    // R3 period
    rfsh_ready = 1'b1;
    wait_valid(n);
    wait_valid(n);
    chk("R3 period of 5", n, 5);
    wait_valid(n);
    chk("R3 period repeats", n, 5);
    // R4 hold under back-pressure, R6 loss
    rfsh_ready = 1'b0;
    wait_valid(n);
    repeat (3) begin @(negedge clk); chk("R4 held while ready low", rfsh_valid, 1); end
    repeat (4) @(negedge clk);
    chk("R6 lost set after overlap", rfsh_lost, 1);
    chk("R6 single request still high", rfsh_valid, 1);
    rfsh_ready = 1'b1;
    repeat (2) @(negedge clk);
    // R7 sticky flag and clear
    wr(2'd1, 16'h0000);
    reg_addr = 2'd1; #1;
    chk("R7 write 0 keeps flag", reg_rdata, 1);
    wr(2'd1, 16'h0001);
    reg_addr = 2'd1; #1;
    chk("R7 write 1 clears flag", reg_rdata, 0);
    reg_addr = 2'd0;
    // R8 zero interval silent
    wr(2'd0, 16'h0000);
    repeat (2) @(negedge clk);
    seen = 0;
    repeat (300) begin @(negedge clk); if (rfsh_valid) seen++; end
    chk("R8 no request at interval 0", seen, 0);
    // R5 lowering below the count waits for the wrap
    wr(2'd0, 16'd200);
    wait_valid(n);
    repeat (100) @(negedge clk);
    wr(2'd0, 16'd50);
    seen = 0;
    repeat (1000) begin @(negedge clk); if (rfsh_valid) seen++; end
    chk("R5 no early request after lowering", seen, 0);
    wait_valid(n);
    chk("R5 request after wrap", int'(n > 15000 && n < 16384), 1);
    wait_valid(n);
    chk("R5 new period used after wrap", n, 50);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule